// File: doc/BRIEF.md
# Character I/O Flag and Interrupt Controller

This block sits between a small accumulator processor and a pair of character devices. It holds one input character and one output character. It also holds a ready flag for each direction, an interrupt-enable bit and the interrupt-request bit. The request bit tells the processor's step sequencer to enter its interrupt cycle in place of the next fetch.

On the device side, the device offers an input byte with a valid strobe. `dev_in_ready` is tied high: the block never applies back-pressure. An offered byte is always taken, and it replaces any byte that has not yet been read. When the processor writes an output byte, the block raises `dev_out_valid` for exactly one cycle. The device later pulses `dev_out_done` to report that it can take another byte. No ready handshake exists on the output side. The ready flag is the only pacing.

On the processor side, the sequencer asserts `io_exec` during the execute step of an I/O instruction, with the six command bits taken straight from the instruction. The block returns three things:
- a combinational skip request,
- an accumulator low-byte load strobe with its data,
- the registered interrupt request.

Top module: `chario_irq_ctrl`

## Requirements
- R1: After reset, the input flag is 0 and the output flag is 1. Interrupt enable, interrupt request and `dev_out_valid` are 0, and `dev_in_ready` is 1 at all times.
- R2: A cycle with `dev_in_valid`=1 stores `dev_in_data` in the input register and sets the input flag at the closing edge.
- R3: With `io_exec`=1 and `io_ops[5]` (input command), `acc_load` is 1 in that cycle and `acc_din` equals the stored input byte. The input flag clears at the closing edge.
- R4: With `io_exec`=1 and `io_ops[4]` (output command), `acc_lo` is stored in the output register and the output flag clears at the closing edge. `dev_out_valid` is 1 for exactly the following cycle, with `dev_out_data` showing the stored byte.
- R5: A cycle with `dev_out_done`=1 sets the output flag at the closing edge.
- R6: `skip_req` is 1 in the same cycle when `io_exec`=1 and either `io_ops[3]`=1 with the input flag set, or `io_ops[2]`=1 with the output flag set. Otherwise it is 0, including whenever `io_exec`=0.
- R7: When a device strobe (`dev_in_valid` or `dev_out_done`) and a processor clear of the same flag occur in one cycle, the flag ends set. The input command still delivers the byte held before that edge.
- R8: `io_ops[1]` with `io_exec` sets interrupt enable, and `io_ops[0]` with `io_exec` clears it.
- R9: The interrupt request sets at an edge only if interrupt enable is 1, at least one flag is 1, and `seq_step` is at least 3, so that steps 0, 1 and 2 never set it. Once set, it holds until `irq_ack`.
- R10: `irq_ack` clears interrupt enable and the interrupt request at the closing edge, and takes priority over an enable command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_in_valid | input | 1 | Device offers an input byte this cycle |
| dev_in_data | input | CHAR_W | Input byte |
| dev_in_ready | output | 1 | Always 1; input is never stalled |
| dev_out_valid | output | 1 | One-cycle pulse: new output byte available |
| dev_out_data | output | CHAR_W | Output register |
| dev_out_done | input | 1 | Device finished the last output byte |
| io_exec | input | 1 | I/O instruction execute step |
| io_ops | input | 6 | Command bits: 5 input, 4 output, 3 skip-on-input, 2 skip-on-output, 1 enable, 0 disable |
| acc_lo | input | CHAR_W | Accumulator low byte |
| acc_load | output | 1 | Load accumulator low byte from `acc_din` |
| acc_din | output | CHAR_W | Input register contents |
| skip_req | output | 1 | Request program-counter increment |
| seq_step | input | STEP_W | Current step number of the sequencer |
| irq_ack | input | 1 | Final step of the interrupt cycle |
| irq_pending | output | 1 | Interrupt request |

## Verification
A flag stuck at the wrong value shows up on `skip_req` in the same cycle that a skip command probes it. Because that probe has no side effect, the bench reads both flags after every stimulus. A wrong enable or request state appears on `irq_pending` one edge after a step at or beyond 3, or right after the acknowledge. A bad data path shows on `acc_din` in the cycle of the input command, and on `dev_out_data` in the cycle after the output command. The bench sweeps every byte value in both directions, and it sweeps all 64 combinations of enable, the two flags and the step number against the request rule.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int OPS_W  = 6;
  localparam int OP_INP = 5;
  localparam int OP_OUT = 4;
  localparam int OP_SKI = 3;
  localparam int OP_SKO = 2;
  localparam int OP_ION = 1;
  localparam int OP_IOF = 0;

  typedef struct packed {
    logic take_in;
    logic put_out;
    logic skip_in;
    logic skip_out;
    logic irq_on;
    logic irq_off;
  } io_cmd_t;

  function automatic io_cmd_t decode_cmd(input logic exec, input logic [OPS_W-1:0] ops);
    io_cmd_t c;
    c.take_in  = exec & ops[OP_INP];
    c.put_out  = exec & ops[OP_OUT];
    c.skip_in  = exec & ops[OP_SKI];
    c.skip_out = exec & ops[OP_SKO];
    c.irq_on   = exec & ops[OP_ION];
    c.irq_off  = exec & ops[OP_IOF];
    return c;
  endfunction
endpackage

// File: rtl/chario_in_port.sv
module chario_in_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CHAR_W-1:0] data,
  input  logic              take,
  output logic [CHAR_W-1:0] hold,
  output logic              full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
    end else begin
      if (strobe) hold <= data;
      if (strobe)    full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end

  a_r2_strobe_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> full);
  a_r2_strobe_stores: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> hold == $past(data));
  a_r3_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !strobe) |=> !full);
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(hold));
endmodule

// File: rtl/chario_out_port.sv
module chario_out_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] acc_lo,
  input  logic              done,
  output logic [CHAR_W-1:0] hold,
  output logic              empty,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      empty <= 1'b1;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) hold <= acc_lo;
      if (done)      empty <= 1'b1;
      else if (load) empty <= 1'b0;
    end
  end

  a_r4_valid_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid && hold == $past(acc_lo));
  a_r4_valid_only_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !valid);
  a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !done) |=> !empty);
  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> empty);
endmodule

// File: rtl/chario_irq.sv
module chario_irq #(
  parameter int STEP_W      = 3,
  parameter int FETCH_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_on,
  input  logic              irq_off,
  input  logic              ack,
  input  logic [STEP_W-1:0] step,
  input  logic              in_flag,
  input  logic              out_flag,
  output logic              enable,
  output logic              request
);
  localparam logic [STEP_W-1:0] FIRST_EXEC = STEP_W'(FETCH_STEPS);

  logic may_set;
  assign may_set = enable & (in_flag | out_flag) & (step >= FIRST_EXEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      request <= 1'b0;
    end else begin
      if (ack || irq_off) enable <= 1'b0;
      else if (irq_on)    enable <= 1'b1;
      if (ack)          request <= 1'b0;
      else if (may_set) request <= 1'b1;
    end
  end

  a_r9_quiet_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!request && step < FIRST_EXEC) |=> !request);
  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!request && !enable) |=> !request);
  a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (request && !ack) |=> request);
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !enable && !request);
  a_r8_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_on && !irq_off && !ack) |=> enable);
  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |=> !enable);
endmodule

// File: rtl/chario_irq_ctrl.sv
module chario_irq_ctrl #(
  parameter int CHAR_W      = 8,
  parameter int STEP_W      = 3,
  parameter int FETCH_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_in_valid,
  input  logic [CHAR_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [CHAR_W-1:0] dev_out_data,
  input  logic              dev_out_done,
  input  logic              io_exec,
  input  logic [5:0]        io_ops,
  input  logic [CHAR_W-1:0] acc_lo,
  output logic              acc_load,
  output logic [CHAR_W-1:0] acc_din,
  output logic              skip_req,
  input  logic [STEP_W-1:0] seq_step,
  input  logic              irq_ack,
  output logic              irq_pending
);
  import chario_pkg::*;

  io_cmd_t cmd;
  logic    in_full, out_empty, irq_en;

  assign cmd = decode_cmd(io_exec, io_ops);

  chario_in_port #(.CHAR_W(CHAR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .strobe(dev_in_valid), .data(dev_in_data),
    .take(cmd.take_in), .hold(acc_din), .full(in_full));

  chario_out_port #(.CHAR_W(CHAR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(cmd.put_out), .acc_lo(acc_lo),
    .done(dev_out_done), .hold(dev_out_data), .empty(out_empty),
    .valid(dev_out_valid));

  chario_irq #(.STEP_W(STEP_W), .FETCH_STEPS(FETCH_STEPS)) u_irq (
    .clk(clk), .rst_n(rst_n), .irq_on(cmd.irq_on), .irq_off(cmd.irq_off),
    .ack(irq_ack), .step(seq_step), .in_flag(in_full), .out_flag(out_empty),
    .enable(irq_en), .request(irq_pending));

  assign dev_in_ready = 1'b1;
  assign acc_load     = cmd.take_in;
  assign skip_req     = (cmd.skip_in & in_full) | (cmd.skip_out & out_empty);

  a_r6_skip_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
    !io_exec |-> !skip_req && !acc_load);
  a_r7_input_never_lost: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_valid |=> in_full);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready);
  a_r9_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(irq_en));
endmodule

// File: tb/chario_irq_ctrl_tb.sv
module chario_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_in_valid, dev_out_done, io_exec, irq_ack;
  logic [7:0] dev_in_data, acc_lo;
  logic [5:0] io_ops;
  logic [2:0] seq_step;
  logic       dev_in_ready, dev_out_valid, acc_load, skip_req, irq_pending;
  logic [7:0] dev_out_data, acc_din;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chario_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_done(dev_out_done), .io_exec(io_exec), .io_ops(io_ops), .acc_lo(acc_lo),
    .acc_load(acc_load), .acc_din(acc_din), .skip_req(skip_req), .seq_step(seq_step),
    .irq_ack(irq_ack), .irq_pending(irq_pending));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dev_in_valid = 0; dev_in_data = 0; dev_out_done = 0; io_exec = 0;
    io_ops = 0; acc_lo = 0; seq_step = 0; irq_ack = 0;
  endtask

  task automatic clk1();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmd(input int op);
    io_exec = 1; io_ops = 6'(1 << op);
  endtask

  // Probe a flag through a skip command; no clock edge passes.
  task automatic probe(input int op, output logic s);
    cmd(op); #1; s = skip_req; io_exec = 0; io_ops = 0; #1;
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; clk1(); clk1(); rst_n = 1;
  endtask

  initial begin
    logic s;
    idle(); rst_n = 0;
    @(negedge clk); clk1(); clk1();
    // R1 reset state
    chk(irq_pending == 0, "R1 irq", irq_pending, 0);
    chk(dev_out_valid == 0, "R1 valid", dev_out_valid, 0);
    chk(dev_in_ready == 1, "R1 ready", dev_in_ready, 1);
    rst_n = 1;
    probe(3, s); chk(s == 0, "R1 in flag", s, 0);
    probe(2, s); chk(s == 1, "R1 out flag", s, 1);
    // R6: exec low gives no skip
    io_ops = 6'b000100; #1; chk(skip_req == 0, "R6 exec low", skip_req, 0); io_ops = 0;

    // R2/R3 sweep over every input byte
    for (int v = 0; v < 256; v++) begin
      dev_in_valid = 1; dev_in_data = 8'(v); clk1(); dev_in_valid = 0;
      probe(3, s); chk(s == 1, "R2 flag set", s, 1);
      cmd(5); #1;
      chk(acc_load == 1 && acc_din == 8'(v), "R3 input data", acc_din, v);
      clk1(); idle();
      probe(3, s); chk(s == 0, "R3 flag clear", s, 0);
    end

    // R4/R5 sweep over every output byte
    for (int v = 0; v < 256; v++) begin
      acc_lo = 8'(v); cmd(4); clk1(); idle();
      chk(dev_out_valid == 1 && dev_out_data == 8'(v), "R4 out data", dev_out_data, v);
      probe(2, s); chk(s == 0, "R4 flag clear", s, 0);
      clk1();
      chk(dev_out_valid == 0, "R4 single pulse", dev_out_valid, 0);
      dev_out_done = 1; clk1(); dev_out_done = 0;
      probe(2, s); chk(s == 1, "R5 done sets", s, 1);
    end

    // R7 collisions
    do_reset();
    dev_in_valid = 1; dev_in_data = 8'h5A; clk1();
    dev_in_data = 8'hC3; cmd(5); #1;
    chk(acc_din == 8'h5A, "R7 old byte", acc_din, 'h5A);
    clk1(); idle();
    probe(3, s); chk(s == 1, "R7 in flag kept", s, 1);
    cmd(5); #1; chk(acc_din == 8'hC3, "R7 new byte", acc_din, 'hC3); clk1(); idle();
    acc_lo = 8'h11; cmd(4); dev_out_done = 1; clk1(); idle();
    probe(2, s); chk(s == 1, "R7 out flag kept", s, 1);

    // R9 sweep: enable x in flag x out flag x step
    for (int c = 0; c < 64; c++) begin
      int en, fi, fo, st, exp;
      en = c & 1; fi = (c >> 1) & 1; fo = (c >> 2) & 1; st = c >> 3;
      do_reset();
      if (fi == 1) begin dev_in_valid = 1; clk1(); idle(); end
      if (fo == 0) begin cmd(4); clk1(); idle(); end
      if (en == 1) begin cmd(1); clk1(); idle(); end
      seq_step = 3'(st); clk1(); seq_step = 0;
      exp = (en == 1 && (fi | fo) == 1 && st >= 3) ? 1 : 0;
      chk(int'(irq_pending) == exp, "R9 request rule", irq_pending, exp);
      clk1();
      chk(int'(irq_pending) == exp, "R9 request holds", irq_pending, exp);
    end

    // R8 disable, R10 ack
    do_reset();
    cmd(1); clk1(); cmd(0); clk1(); idle();
    seq_step = 4; clk1(); seq_step = 0;
    chk(irq_pending == 0, "R8 disabled", irq_pending, 0);
    cmd(1); clk1(); idle(); seq_step = 5; clk1(); seq_step = 0;
    chk(irq_pending == 1, "R8 enabled", irq_pending, 1);
    irq_ack = 1; cmd(1); clk1(); idle();
    chk(irq_pending == 0, "R10 ack clears", irq_pending, 0);
    seq_step = 6; clk1(); seq_step = 0;
    chk(irq_pending == 0, "R10 enable cleared", irq_pending, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule